// File: doc/BRIEF.md
# I2C SDA Output Delay

This block sits between the bit engine of an I2C master and the driver of the SDA pad. Whenever the clock line it is given falls, it holds the SDA output at its old level for a programmable number of baud units, then lets it take the level the engine asks for. The same hold-off applies when the engine asks for a new SDA level while SCL is high, as it does for start, repeated start and stop conditions. This keeps SDA edges clear of the slow falling slope of SCL, so slaves never see data move while the clock is still falling.

A baud unit is one period of a tick enable. A prescaler on the peripheral clock produces this tick, and its divisor is set by a 2-bit select. The delay is a 5-bit count of such units, from 0 to 31. Software must pick a value longer than the bus fall time. The block does not check this. The output is a registered level, and a busy flag shows that a change is pending.

Top module: `i2c_sda_delay`

## Requirements
- R1: While and after a synchronous reset, `sda_o` is 1 (released) and `busy_o` is 0.
- R2: The baud-unit length D follows `div_sel_i`: 00 gives 1 clock, 01 gives 4, 10 gives 16 and 11 gives 64 clocks. The unit phase restarts at every delay load.
- R3: An SCL falling edge is a clock edge that samples `scl_i` low after the previous edge sampled it high. With a setting N > 0, `sda_o` takes `sda_req_i` exactly N*D clock edges after that sampling edge. This holds up to N = 31 with D = 64 (1984 clocks).
- R4: With N = 0, `sda_o` takes `sda_req_i` at the same edge that samples the SCL fall, with no added delay.
- R5: While `busy_o` stays high, `sda_o` does not change.
- R6: An SCL falling edge that arrives while a delay is pending restarts the full N*D count from the new edge.
- R7: While no delay is pending, a `sda_req_i` level that differs from `sda_o` (for example a start or stop condition with SCL high) loads the same delay. `sda_o` follows N*D edges after the first edge that samples the difference.
- R8: Changes of `sda_req_i` while a delay is pending do not affect timing. `sda_o` takes the level `sda_req_i` has at the expiry edge.
- R9: `busy_o` is high from the load edge until the edge at which `sda_o` is updated, and it drops at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_i | input | 1 | Synchronous active-high reset |
| div_sel_i | input | 2 | Prescaler select for the baud-unit length |
| dly_units_i | input | 5 | Delay in baud units (0 to 31) |
| scl_i | input | 1 | Current SCL output level from the bit engine |
| sda_req_i | input | 1 | SDA level requested by the bit engine |
| sda_o | output | 1 | Delayed SDA level for the pad driver |
| busy_o | output | 1 | A delayed SDA change is pending |

## Verification
The assertions check several properties on every cycle. `sda_o` is frozen while a delay stays pending. Every output change copies the requested level of that edge. Busy always carries a nonzero remaining count. Slow divisors never produce back-to-back ticks. Exact latencies need the bench's directed scenarios: N*D across all four divisors, the zero setting, the 1984-clock maximum, the restart on a second fall, the late request and the start/stop path with SCL high. The assertions cannot measure these window lengths.

// File: rtl/i2c_sda_delay_pkg.sv
package i2c_sda_delay_pkg;
  localparam int SEL_W     = 2;
  localparam int DIV_SHIFT = 2;
  localparam int DLY_W     = 5;

  typedef enum logic {
    DLY_IDLE  = 1'b0,
    DLY_COUNT = 1'b1
  } dly_state_e;
endpackage

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int SEL_W     = 2,
  parameter int DIV_SHIFT = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             restart_i,
  output logic             tick_o
);
  localparam int MAX_LOG = DIV_SHIFT * ((1 << SEL_W) - 1);
  localparam int CNT_W   = (MAX_LOG > 0) ? MAX_LOG : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   div_val;
  logic [CNT_W:0]   term_val;

  assign div_val  = {{CNT_W{1'b0}}, 1'b1} << (DIV_SHIFT * int'(sel_i));
  assign term_val = div_val - {{CNT_W{1'b0}}, 1'b1};
  assign tick_o   = ({1'b0, cnt_q} >= term_val);

  always_ff @(posedge clk_i) begin
    if (rst_i || restart_i) begin
      cnt_q <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/scl_fall_detect.sv
module scl_fall_detect (
  input  logic clk_i,
  input  logic rst_i,
  input  logic scl_i,
  output logic fall_o
);
  logic scl_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) scl_q <= 1'b1;
    else       scl_q <= scl_i;
  end

  assign fall_o = scl_q & ~scl_i;
endmodule

// File: rtl/sda_delay_core.sv
module sda_delay_core
  import i2c_sda_delay_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             fall_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] dly_i,
  input  logic             sda_req_i,
  output logic             sda_o,
  output logic             busy_o,
  output logic             load_o,
  output logic [CNT_W-1:0] cnt_o
);
  dly_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             sda_q;
  logic             mismatch;
  logic             load;
  logic             expire;

  assign mismatch = (sda_req_i != sda_q);
  assign load     = fall_i | ((state_q == DLY_IDLE) & mismatch);
  assign expire   = (state_q == DLY_COUNT) & tick_i & (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= DLY_IDLE;
      cnt_q   <= '0;
      sda_q   <= 1'b1;
    end else if (load) begin
      if (dly_i == '0) begin
        state_q <= DLY_IDLE;
        cnt_q   <= '0;
        sda_q   <= sda_req_i;
      end else begin
        state_q <= DLY_COUNT;
        cnt_q   <= dly_i;
      end
    end else if (expire) begin
      state_q <= DLY_IDLE;
      cnt_q   <= '0;
      sda_q   <= sda_req_i;
    end else if ((state_q == DLY_COUNT) && tick_i) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign sda_o  = sda_q;
  assign busy_o = (state_q == DLY_COUNT);
  assign load_o = load;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/i2c_sda_delay.sv
module i2c_sda_delay
  import i2c_sda_delay_pkg::*;
#(
  parameter int SEL_BITS = SEL_W,
  parameter int DIV_STEP = DIV_SHIFT,
  parameter int DLY_BITS = DLY_W
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [SEL_BITS-1:0] div_sel_i,
  input  logic [DLY_BITS-1:0] dly_units_i,
  input  logic                scl_i,
  input  logic                sda_req_i,
  output logic                sda_o,
  output logic                busy_o
);
  logic                baud_tick;
  logic                scl_fall;
  logic                dly_load;
  logic [DLY_BITS-1:0] dly_cnt;

  scl_fall_detect u_fall (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .scl_i  (scl_i),
    .fall_o (scl_fall)
  );

  baud_tick_gen #(
    .SEL_W     (SEL_BITS),
    .DIV_SHIFT (DIV_STEP)
  ) u_tick (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .sel_i     (div_sel_i),
    .restart_i (dly_load),
    .tick_o    (baud_tick)
  );

  sda_delay_core #(
    .CNT_W (DLY_BITS)
  ) u_core (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .fall_i    (scl_fall),
    .tick_i    (baud_tick),
    .dly_i     (dly_units_i),
    .sda_req_i (sda_req_i),
    .sda_o     (sda_o),
    .busy_o    (busy_o),
    .load_o    (dly_load),
    .cnt_o     (dly_cnt)
  );
endmodule

// File: rtl/i2c_sda_delay_chk.sv
module i2c_sda_delay_chk #(
  parameter int SEL_BITS = 2,
  parameter int DLY_BITS = 5
) (
  input logic                clk_i,
  input logic                rst_i,
  input logic [SEL_BITS-1:0] div_sel_i,
  input logic                sda_req_i,
  input logic                sda_o,
  input logic                busy_o,
  input logic                tick,
  input logic [DLY_BITS-1:0] cnt
);
  AST_RESET_RELEASE: assert property (@(posedge clk_i)
    rst_i |=> (sda_o && !busy_o)); // R1

  AST_DIV1_TICKS: assert property (@(posedge clk_i) disable iff (rst_i)
    (div_sel_i == '0) |-> tick); // R2

  AST_SLOW_TICK_SPACED: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick && div_sel_i != '0) |=> (!tick || div_sel_i == '0)); // R2

  AST_BUSY_HAS_COUNT: assert property (@(posedge clk_i) disable iff (rst_i)
    busy_o |-> (cnt != '0)); // R3

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(busy_o) && busy_o) |-> $stable(sda_o)); // R5

  AST_OUT_FROM_REQ: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(sda_o) |-> (sda_o == $past(sda_req_i))); // R8

  AST_BUSY_DROP_UPDATES: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(busy_o) |-> (sda_o == $past(sda_req_i))); // R9
endmodule

bind i2c_sda_delay i2c_sda_delay_chk #(
  .SEL_BITS (SEL_BITS),
  .DLY_BITS (DLY_BITS)
) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .div_sel_i (div_sel_i),
  .sda_req_i (sda_req_i),
  .sda_o     (sda_o),
  .busy_o    (busy_o),
  .tick      (baud_tick),
  .cnt       (dly_cnt)
);

// File: tb/i2c_sda_delay_tb.sv
`timescale 1ns/1ps
module i2c_sda_delay_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] sel = 2'd0;
  logic [4:0] dly = 5'd0;
  logic       scl = 1'b1;
  logic       req = 1'b1;
  logic       sda_o;
  logic       busy_o;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  i2c_sda_delay u_dut (
    .clk_i       (clk),
    .rst_i       (rst),
    .div_sel_i   (sel),
    .dly_units_i (dly),
    .scl_i       (scl),
    .sda_req_i   (req),
    .sda_o       (sda_o),
    .busy_o      (busy_o)
  );

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // Latency counted in clock edges from the first edge after the drive.
  task automatic measure(input logic exp_val, output int lat, output bit busy_ok);
    lat = 0;
    busy_ok = 1'b1;
    while (1) begin
      @(posedge clk); #2;
      if (sda_o === exp_val) break;
      if (busy_o !== 1'b1) busy_ok = 1'b0;
      lat++;
      if (lat > 4000) break;
    end
  endtask

  task automatic settle_high();
    @(negedge clk); scl = 1'b1; req = sda_o;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(sda_o === 1'b1, "R1", "sda after reset", int'(sda_o), 1);
    check(busy_o === 1'b0, "R1", "busy after reset", int'(busy_o), 0);
  endtask

  task automatic t_div(input logic [1:0] s);
    int lat; bit bok; logic v; int d;
    d = 1 << (2 * int'(s));
    settle_high();
    sel = s; dly = 5'd3;
    @(negedge clk);
    v = ~sda_o; req = v; scl = 1'b0;
    measure(v, lat, bok);
    check(lat == 3 * d, "R2", "latency for divisor", lat, 3 * d);
    check(bok, "R9", "busy held before update", int'(bok), 1);
    check(busy_o === 1'b0, "R9", "busy drops with update", int'(busy_o), 0);
  endtask

  task automatic t_zero();
    int lat; bit bok; logic v;
    settle_high();
    sel = 2'd2; dly = 5'd0;
    @(negedge clk);
    v = ~sda_o; req = v; scl = 1'b0;
    measure(v, lat, bok);
    check(lat == 0, "R4", "zero delay latency", lat, 0);
    check(busy_o === 1'b0, "R4", "busy with zero delay", int'(busy_o), 0);
  endtask

  task automatic t_max();
    int lat; bit bok; logic v;
    settle_high();
    sel = 2'd3; dly = 5'd31;
    @(negedge clk);
    v = ~sda_o; req = v; scl = 1'b0;
    measure(v, lat, bok);
    check(lat == 1984, "R3", "maximum delay latency", lat, 1984);
    check(bok, "R3", "busy through maximum delay", int'(bok), 1);
  endtask

  task automatic t_restart();
    int lat; bit bok; logic v; logic old;
    settle_high();
    sel = 2'd0; dly = 5'd10;
    @(negedge clk);
    old = sda_o; v = ~sda_o; req = v; scl = 1'b0;
    repeat (4) @(negedge clk);
    scl = 1'b1;
    @(negedge clk);
    scl = 1'b0;
    check(sda_o === old, "R5", "sda held before restart", int'(sda_o), int'(old));
    check(busy_o === 1'b1, "R6", "busy before second fall", int'(busy_o), 1);
    measure(v, lat, bok);
    check(lat == 10, "R6", "latency from second fall", lat, 10);
  endtask

  task automatic t_late_req();
    int lat; bit bok; logic s;
    settle_high();
    sel = 2'd1; dly = 5'd8;
    @(negedge clk);
    s = sda_o; req = s; scl = 1'b0;
    repeat (5) @(negedge clk);
    req = ~s;
    repeat (5) @(negedge clk);
    check(sda_o === s, "R8", "late request not applied early", int'(sda_o), int'(s));
    measure(~s, lat, bok);
    check(lat == 22, "R8", "late request applied at expiry", lat, 22);
    check(bok, "R5", "busy while held", int'(bok), 1);
  endtask

  task automatic t_start_stop();
    int lat; bit bok; logic v;
    settle_high();
    sel = 2'd1; dly = 5'd5;
    @(negedge clk);
    v = ~sda_o; req = v;
    measure(v, lat, bok);
    check(lat == 20, "R7", "first request with SCL high", lat, 20);
    @(negedge clk);
    v = ~sda_o; req = v;
    measure(v, lat, bok);
    check(lat == 20, "R7", "second request with SCL high", lat, 20);
    check(bok, "R7", "busy during request delay", int'(bok), 1);
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_reset();
    for (int i = 0; i < 4; i++) t_div(2'(i));
    t_zero();
    t_max();
    t_restart();
    t_late_req();
    t_start_stop();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule